// File: doc/BRIEF.md
# Seconds Prescaler with Trim Correction

This block turns a 32768 Hz enable stream into a one-cycle seconds tick for a real-time clock. It counts enables in two cascaded stages: a fine stage of 2^LO_W enables (256 by default) and a coarse stage of 2^HI_W fine periods (128 by default). The seconds counter that consumes the tick lives elsewhere.

Two trims adjust the rate, and a single 32-bit configuration word written through `cfg_we`/`cfg_wdata` controls both. The first is a periodic whole-second correction. Once every match+1 seconds it either adds a tick or drops one. An added tick is a second `sec_tick` pulse on the next cycle, marked by `extra_tick`. A dropped tick is replaced by a `skip_tick` pulse. The second trim is a one-shot request. At the next fine-stage boundary it lengthens that fine period to twice its length or shrinks it to zero length, which moves time by 1/128 s at default sizes. The request then clears itself.

Top module: `rtc_trim_prescaler`

## Requirements
- R1: After reset all outputs are 0. The first `sec_tick` comes after exactly 2^(LO_W+HI_W) enables. Later ticks come every 2^(LO_W+HI_W) enables. Each tick is a one-cycle pulse in the cycle after the edge that takes the last enable of the second.
- R2: Cycles with `tick_en` low do not advance the divider. Spacing counted in enables is unchanged whatever gaps lie between enables.
- R3: Configuration word fields: bits 18:0 are the match value, bits 20:19 the periodic mode, bit 23 the periodic valid bit, bit 24 the trim direction (1 lengthen, 0 shorten) and bit 25 the trim request. A `cfg_we` cycle loads all fields at once.
- R4: A shorten request applies at the next fine-stage boundary. It removes one fine period (2^LO_W enables) from the second that contains that boundary. The request applies once only, and the seconds after it have nominal length.
- R5: A lengthen request applies at the next fine-stage boundary. It adds one fine period to that second, once only.
- R6: With valid=1 and mode 3, every (match+1)-th second boundary gives two `sec_tick` pulses on consecutive cycles. `extra_tick` is high with the second pulse only.
- R7: With valid=1 and mode 2, every (match+1)-th second boundary gives no `sec_tick`. `skip_tick` pulses instead. With match=0 every second is dropped.
- R8: With valid=0, or with mode 0 or mode 1, there is no periodic correction: no `skip_tick`, no `extra_tick`, and nominal spacing.
- R9: Any configuration write restarts the periodic interval count. The next correction falls on the (match+1)-th boundary after the write.
- R10: A shorten applied at the last fine period of a second carries into the coarse stage. The tick for that second is on time, and the following second is one fine period short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle enable at the 32768 Hz rate |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word |
| sec_tick | output | 1 | Seconds tick pulse |
| extra_tick | output | 1 | Marks the added tick of an insert correction |
| skip_tick | output | 1 | Pulses in place of a dropped tick |

## Verification
The assertions assume that seconds last many cycles, so a boundary never falls on the cycle right after another boundary. They also assume that the configuration word is not rewritten in the cycle between a correction boundary and its extra tick. The stimulus uses a small divider (16 enables per second) and writes only on the cycle of a main tick or in the quiet middle of a second, never just after an insert. The spacing of every event is checked in enables against arithmetic expected values, under dense and sparse enable patterns.

// File: rtl/rtc_trim_pkg.sv
package rtc_trim_pkg;

  localparam int MATCH_W      = 19;
  localparam int MATCH_LSB    = 0;
  localparam int MODE_LSB     = 19;
  localparam int VALID_BIT    = 23;
  localparam int TRIM_DIR_BIT = 24;
  localparam int TRIM_REQ_BIT = 25;

  typedef enum logic [1:0] {
    CORR_OFF0    = 2'd0,
    CORR_OFF1    = 2'd1,
    CORR_SWALLOW = 2'd2,
    CORR_INSERT  = 2'd3
  } corr_mode_e;

  typedef struct packed {
    logic               valid;
    corr_mode_e         mode;
    logic [MATCH_W-1:0] match;
  } period_cfg_t;

  // Advance of the coarse stage at a fine-stage boundary:
  // nominal 1, lengthened period 0, zero-length period 2.
  function automatic logic [1:0] coarse_step(logic wrap, logic pend, logic lengthen);
    if (!wrap)    return 2'd0;
    if (!pend)    return 2'd1;
    if (lengthen) return 2'd0;
    return 2'd2;
  endfunction

  function automatic logic corr_enabled(period_cfg_t c);
    return c.valid && c.mode[1];
  endfunction

endpackage

// File: rtl/rtc_trim_cfg.sv
module rtc_trim_cfg
  import rtc_trim_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [31:0] cfg_wdata,
  input  logic        trim_taken,
  output period_cfg_t pcfg,
  output logic        trim_pend,
  output logic        trim_lengthen,
  output logic        restart
);

  logic unused_bits;
  assign unused_bits = ^{cfg_wdata[31:26], cfg_wdata[22:21]};

  assign restart = cfg_we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcfg          <= '0;
      trim_pend     <= 1'b0;
      trim_lengthen <= 1'b0;
    end else if (cfg_we) begin
      pcfg.valid    <= cfg_wdata[VALID_BIT];
      pcfg.mode     <= corr_mode_e'(cfg_wdata[MODE_LSB +: 2]);
      pcfg.match    <= cfg_wdata[MATCH_LSB +: MATCH_W];
      trim_pend     <= cfg_wdata[TRIM_REQ_BIT];
      trim_lengthen <= cfg_wdata[TRIM_DIR_BIT];
    end else if (trim_taken) begin
      trim_pend     <= 1'b0;
    end
  end

endmodule

// File: rtl/rtc_trim_divider.sv
module rtc_trim_divider
  import rtc_trim_pkg::*;
#(
  parameter int LO_W = 8,
  parameter int HI_W = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic trim_pend,
  input  logic trim_lengthen,
  output logic fine_wrap,
  output logic trim_taken,
  output logic sec_evt
);

  localparam int SUM_W = HI_W + 1;
  localparam logic [LO_W-1:0] LO_MAX = {LO_W{1'b1}};

  logic [LO_W-1:0]  lo_q;
  logic [HI_W-1:0]  hi_q;
  logic [1:0]       step;
  logic [SUM_W-1:0] hi_sum;

  assign fine_wrap  = tick_en && (lo_q == LO_MAX);
  assign step       = coarse_step(fine_wrap, trim_pend, trim_lengthen);
  assign hi_sum     = {1'b0, hi_q} + SUM_W'(step);
  assign sec_evt    = hi_sum[HI_W];
  assign trim_taken = fine_wrap && trim_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (tick_en) begin
      lo_q <= lo_q + LO_W'(1);
      if (fine_wrap) hi_q <= hi_sum[HI_W-1:0];
    end
  end

endmodule

// File: rtl/rtc_trim_corrector.sv
module rtc_trim_corrector
  import rtc_trim_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sec_evt,
  input  logic        restart,
  input  period_cfg_t pcfg,
  output logic        corr_hit,
  output logic        sec_tick,
  output logic        extra_tick,
  output logic        skip_tick
);

  logic [MATCH_W-1:0] ival_q;
  logic               corr_on;
  logic               do_swallow;
  logic               do_insert;
  logic               dbl_q;

  assign corr_on    = corr_enabled(pcfg);
  assign corr_hit   = sec_evt && corr_on && (ival_q == pcfg.match);
  assign do_swallow = corr_hit && (pcfg.mode == CORR_SWALLOW);
  assign do_insert  = corr_hit && (pcfg.mode == CORR_INSERT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ival_q     <= '0;
      dbl_q      <= 1'b0;
      sec_tick   <= 1'b0;
      extra_tick <= 1'b0;
      skip_tick  <= 1'b0;
    end else begin
      if (restart)
        ival_q <= '0;
      else if (sec_evt && corr_on)
        ival_q <= corr_hit ? '0 : ival_q + MATCH_W'(1);
      dbl_q      <= do_insert;
      sec_tick   <= (sec_evt && !do_swallow) || dbl_q;
      extra_tick <= dbl_q;
      skip_tick  <= do_swallow;
    end
  end

endmodule

// File: rtl/rtc_trim_prescaler.sv
module rtc_trim_prescaler
  import rtc_trim_pkg::*;
#(
  parameter int LO_W = 8,
  parameter int HI_W = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_en,
  input  logic        cfg_we,
  input  logic [31:0] cfg_wdata,
  output logic        sec_tick,
  output logic        extra_tick,
  output logic        skip_tick
);

  period_cfg_t pcfg;
  logic        trim_pend;
  logic        trim_lengthen;
  logic        trim_taken;
  logic        restart;
  logic        fine_wrap;
  logic        sec_evt;
  logic        corr_hit;
  logic        cfg_valid;
  logic [1:0]  cfg_mode;

  assign cfg_valid = pcfg.valid;
  assign cfg_mode  = pcfg.mode;

  rtc_trim_cfg u_cfg (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_we        (cfg_we),
    .cfg_wdata     (cfg_wdata),
    .trim_taken    (trim_taken),
    .pcfg          (pcfg),
    .trim_pend     (trim_pend),
    .trim_lengthen (trim_lengthen),
    .restart       (restart)
  );

  rtc_trim_divider #(.LO_W(LO_W), .HI_W(HI_W)) u_div (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick_en       (tick_en),
    .trim_pend     (trim_pend),
    .trim_lengthen (trim_lengthen),
    .fine_wrap     (fine_wrap),
    .trim_taken    (trim_taken),
    .sec_evt       (sec_evt)
  );

  rtc_trim_corrector u_corr (
    .clk        (clk),
    .rst_n      (rst_n),
    .sec_evt    (sec_evt),
    .restart    (restart),
    .pcfg       (pcfg),
    .corr_hit   (corr_hit),
    .sec_tick   (sec_tick),
    .extra_tick (extra_tick),
    .skip_tick  (skip_tick)
  );

endmodule

// File: rtl/rtc_trim_prescaler_chk.sv
module rtc_trim_prescaler_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_en,
  input logic       cfg_we,
  input logic       sec_tick,
  input logic       extra_tick,
  input logic       skip_tick,
  input logic       sec_evt,
  input logic       corr_hit,
  input logic       trim_taken,
  input logic       trim_pend,
  input logic       cfg_valid,
  input logic [1:0] cfg_mode
);

  // R1: a main tick needs an enable on the edge that produced it
  a_r1_tick_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !extra_tick) |-> $past(tick_en));

  // R1: an uncorrected boundary is followed by a tick
  a_r1_evt_to_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_evt && !corr_hit) |=> sec_tick);

  // R4: a taken trim request is gone on the next cycle unless rewritten
  a_r4_trim_once: assert property (@(posedge clk) disable iff (!rst_n)
    (trim_taken && !cfg_we) |=> !trim_pend);

  // R6: the added tick directly follows a tick, under insert mode
  a_r6_extra_follows: assert property (@(posedge clk) disable iff (!rst_n)
    extra_tick |-> (sec_tick && $past(sec_tick)));

  a_r6_extra_mode: assert property (@(posedge clk) disable iff (!rst_n)
    extra_tick |-> $past(cfg_valid && cfg_mode == 2'd3, 2));

  // R7: a dropped tick never coincides with a tick, and only in swallow mode
  a_r7_skip_excl: assert property (@(posedge clk) disable iff (!rst_n)
    skip_tick |-> !sec_tick);

  a_r7_skip_mode: assert property (@(posedge clk) disable iff (!rst_n)
    skip_tick |-> $past(cfg_valid && cfg_mode == 2'd2));

endmodule

bind rtc_trim_prescaler rtc_trim_prescaler_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick_en    (tick_en),
  .cfg_we     (cfg_we),
  .sec_tick   (sec_tick),
  .extra_tick (extra_tick),
  .skip_tick  (skip_tick),
  .sec_evt    (sec_evt),
  .corr_hit   (corr_hit),
  .trim_taken (trim_taken),
  .trim_pend  (trim_pend),
  .cfg_valid  (cfg_valid),
  .cfg_mode   (cfg_mode)
);

// File: tb/sim_rtc_trim_prescaler.sv
module sim_rtc_trim_prescaler;

  localparam int LO_W = 2;
  localparam int HI_W = 2;
  localparam int FINE = 1 << LO_W;
  localparam int SEC  = 1 << (LO_W + HI_W);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        sec_tick, extra_tick, skip_tick;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int en_cnt = 0;
  int en_div = 1;
  bit run_en = 1'b0;
  bit done = 1'b0;
  int last_cnt = 0;
  int last_cy = 0;

  rtc_trim_prescaler #(.LO_W(LO_W), .HI_W(HI_W)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .sec_tick(sec_tick), .extra_tick(extra_tick),
    .skip_tick(skip_tick)
  );

  always #2 clk = ~clk;

  always @(negedge clk) begin
    cyc     <= cyc + 1;
    tick_en <= run_en && ((cyc % en_div) == 0);
  end

  always @(posedge clk) if (tick_en) en_cnt <= en_cnt + 1;

  // Event kinds: 0 main tick, 1 added tick, 2 dropped tick
  function automatic logic [31:0] word(bit valid, int mode, int match, bit req, bit lengthen);
    return (32'(req) << 25) | (32'(lengthen) << 24) | (32'(valid) << 23) |
           (32'(mode & 3) << 19) | 32'(match);
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic next_evt(output int kind, output int cnt, output int cy);
    kind = -1; cnt = 0; cy = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      cfg_we = 1'b0;
      if (sec_tick || skip_tick) begin
        kind = skip_tick ? 2 : (extra_tick ? 1 : 0);
        cnt  = en_cnt;
        cy   = cyc;
        return;
      end
    end
  endtask

  task automatic expect_kind(int exp_kind, int gap, string tag);
    int k, c, y;
    next_evt(k, c, y);
    chk(k == exp_kind, tag, "event kind", k, exp_kind);
    chk(c - last_cnt == gap, tag, "enables since last", c - last_cnt, gap);
    last_cnt = c;
    last_cy  = y;
  endtask

  task automatic expect_extra(string tag);
    int k, c, y;
    next_evt(k, c, y);
    chk(k == 1, tag, "added tick kind", k, 1);
    chk(y == last_cy + 1, tag, "added tick cycle offset", y - last_cy, 1);
  endtask

  task automatic write_cfg(logic [31:0] w);
    cfg_wdata = w;
    cfg_we    = 1'b1;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cfg_we = 1'b0;
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int y0;
    repeat (5) @(negedge clk);
    chk(!sec_tick && !extra_tick && !skip_tick, "R1", "outputs in reset",
        {sec_tick, extra_tick, skip_tick}, 0);
    rst_n  = 1'b1;
    run_en = 1'b1;

    // R1: nominal spacing from reset
    expect_kind(0, SEC, "R1");
    expect_kind(0, SEC, "R1");
    expect_kind(0, SEC, "R1");

    // R2: sparse enables
    en_div = 3;
    expect_kind(0, SEC, "R2");
    y0 = last_cy;
    expect_kind(0, SEC, "R2");
    chk(last_cy - y0 == SEC * 3, "R2", "cycles per second", last_cy - y0, SEC * 3);
    en_div = 1;
    expect_kind(0, SEC, "R2");
    expect_kind(0, SEC, "R2");

    // R4 R3: shorten request (bit 25 set, bit 24 clear)
    write_cfg(word(0, 0, 0, 1, 0));
    expect_kind(0, SEC - FINE, "R4");
    expect_kind(0, SEC, "R4");

    // R5 R3: lengthen request (bits 25 and 24 set)
    write_cfg(word(0, 0, 0, 1, 1));
    expect_kind(0, SEC + FINE, "R5");
    expect_kind(0, SEC, "R5");

    // R10: shorten applied at last fine period of a second
    idle(SEC - FINE);
    write_cfg(word(0, 0, 0, 1, 0));
    expect_kind(0, SEC, "R10");
    expect_kind(0, SEC - FINE, "R10");
    expect_kind(0, SEC, "R10");

    // R7 R3: swallow every third second
    write_cfg(word(1, 2, 2, 0, 0));
    expect_kind(0, SEC, "R7");
    expect_kind(0, SEC, "R7");
    expect_kind(2, SEC, "R7");
    expect_kind(0, SEC, "R7");
    expect_kind(0, SEC, "R7");
    expect_kind(2, SEC, "R7");

    // R9: rewrite restarts interval count
    expect_kind(0, SEC, "R9");
    expect_kind(0, SEC, "R9");
    write_cfg(word(1, 2, 2, 0, 0));
    expect_kind(0, SEC, "R9");
    expect_kind(0, SEC, "R9");
    expect_kind(2, SEC, "R9");

    // R7: match 0 drops every second
    write_cfg(word(1, 2, 0, 0, 0));
    expect_kind(2, SEC, "R7");
    expect_kind(2, SEC, "R7");

    // R6 R3: insert every second boundary
    write_cfg(word(1, 3, 1, 0, 0));
    expect_kind(0, SEC, "R6");
    expect_kind(0, SEC, "R6");
    expect_extra("R6");
    expect_kind(0, SEC, "R6");
    expect_kind(0, SEC, "R6");
    expect_extra("R6");

    // R8: insert mode without valid, then modes 1 and 0 with valid
    expect_kind(0, SEC, "R8");
    write_cfg(word(0, 3, 0, 0, 0));
    expect_kind(0, SEC, "R8");
    expect_kind(0, SEC, "R8");
    expect_kind(0, SEC, "R8");
    write_cfg(word(1, 1, 0, 0, 0));
    expect_kind(0, SEC, "R8");
    expect_kind(0, SEC, "R8");
    write_cfg(word(1, 0, 0, 0, 0));
    expect_kind(0, SEC, "R8");
    expect_kind(0, SEC, "R8");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule